// File: doc/BRIEF.md
# PROM Blank-Check and Supply-Margin Read Sweeper

This controller reads every word of an external one-time-programmable memory and compares each word against an expected value. It has two run modes. The blank mode makes one pass at the nominal supply. In that pass every word must read as zero, and the expected-image lookup is ignored. The margin mode makes two passes. The first runs at a reduced supply setting and the second at a raised one. In both, each word is compared against the image returned by the lookup port for the same address. The supply itself is generated outside the block. The controller only drives a level-select code and waits a settling time after each change.

Each word is read with an enable-strobed cycle. Chip enable is held high for a delay, the address is then presented, and after a setup time chip enable goes low. The data is sampled at the end of the access window. The first mismatch is recorded with its address, its observed data and the pass in which it occurred. Any mismatch makes the device a reject. An optional stop-on-fail setting ends the run at the first mismatching read.

Top module: `prom_margin_sweeper`

## Requirements
- R1: After reset, `prom_ce_n` is 1, `prom_oe_n` is 0, `supply_sel` is 2'b00 (nominal), `prom_addr` is 0, `pass_num` is 0, and `busy`, `done` and `fail_seen` are 0.
- R2: A `start` pulse sampled in idle with `margin_mode`=0 runs one pass with `pass_num`=0 at `supply_sel`=2'b00, and expects every word to be 8'h00 whatever `ref_data` returns.
- R3: A `start` pulse with `margin_mode`=1 runs pass 1 at `supply_sel`=2'b01 (low) and then pass 2 at `supply_sel`=2'b10 (high). Each word is compared with `ref_data`, which is read at `ref_addr`; `ref_addr` equals `prom_addr`.
- R4: After every change of `supply_sel` at the start of a pass, chip enable stays high for TD_CYC cycles before the first word's read sequence begins. The supply code does not change while chip enable is low.
- R5: Each word's read sequence is TD_CYC cycles with chip enable high and the previous address, then SETUP_CYC cycles with chip enable high and the new address, then ACCESS_CYC cycles with chip enable low. Data is sampled on the last of those low cycles.
- R6: Within a pass, addresses are read in ascending order from 0 to 2^ADDR_W-1. The address does not change while chip enable is low.
- R7: When the run finishes, `device_ok` is 1 only if no read mismatched. `fail_seen`, `fail_addr`, `fail_data` and `fail_pass` hold the first mismatch of the run, and later mismatches never overwrite it.
- R8: With `stop_on_fail` latched at 1, the run ends at the read of the first mismatch. This holds even on the last word of the low pass, in which case the high pass is skipped.
- R9: When a run finishes, `busy` falls, `done` rises, `supply_sel` returns to 2'b00 and chip enable is high. `done` stays high until the next accepted `start`.
- R10: A `start` pulse while `busy` is high has no effect on the sequence, the mode or the stop setting.
- R11: `prom_oe_n` is 0 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a run (sampled in idle only) |
| margin_mode | input | 1 | 0 = blank check, 1 = low then high margin passes |
| stop_on_fail | input | 1 | End the run at the first mismatch |
| supply_sel | output | 2 | Supply level code: 00 nominal, 01 low, 10 high |
| prom_ce_n | output | 1 | Memory chip enable, active low |
| prom_oe_n | output | 1 | Memory output enable, held low |
| prom_addr | output | ADDR_W | Memory word address |
| prom_data | input | DATA_W | Memory read data |
| ref_addr | output | ADDR_W | Expected-image lookup address |
| ref_data | input | DATA_W | Expected-image word for ref_addr |
| busy | output | 1 | Run in progress |
| done | output | 1 | Last run finished |
| device_ok | output | 1 | Last run finished with no mismatch |
| fail_seen | output | 1 | A mismatch was recorded in this run |
| pass_num | output | 2 | Current or last pass: 0 blank, 1 low, 2 high |
| fail_pass | output | 2 | Pass of the first mismatch |
| fail_addr | output | ADDR_W | Address of the first mismatch |
| fail_data | output | DATA_W | Data observed at the first mismatch |

## Verification
The first-failure capture can fall on the same clock edge as the end of a pass. When the mismatching word is the last address, one edge has to record the failure and also either switch to the high supply, finish the run, or, with stop-on-fail, abort instead of moving on. The bench provokes this with a word that reads wrong only at the high supply on the final address, and with another that reads wrong only at the low supply on the final address with stop-on-fail set. It judges the outcome cycle by cycle against a schedule built beforehand: the supply code, the chip-enable pattern and the captured failure fields must all match. A further run issues a second `start` mid-sweep with the mode flipped, to show that the pulse is ignored.

// File: rtl/prom_sweep_pkg.sv
// Shared types for the PROM read sweeper.
// Assumes: supply codes are decoded by an external regulator; the code
// for each pass equals the pass number so status and supply line up.
package prom_sweep_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETTLE,
        ST_GAP,
        ST_SETUP,
        ST_ACCESS
    } sweep_state_t;

    typedef enum logic [1:0] {
        PASS_BLANK = 2'd0,
        PASS_LOW   = 2'd1,
        PASS_HIGH  = 2'd2
    } sweep_pass_t;

    localparam logic [1:0] SUP_NOM  = 2'b00;
    localparam logic [1:0] SUP_LOW  = 2'b01;
    localparam logic [1:0] SUP_HIGH = 2'b10;

endpackage

// File: rtl/sweep_delay.sv
// Shared wait timer: loaded with N-1 when a timed phase begins, it reads
// zero during the last cycle of that phase.
// Assumes: the loader always gives a value of at least 0 (phases >= 1 cycle).
module sweep_delay #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    // Load on phase entry, otherwise count down to zero and hold there.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/sweep_addr_gen.sv
// Word index counter and the presented-address register.
// The index advances after each read; the address seen by the memory only
// changes when the controller asks to present it (after the CE-high delay).
module sweep_addr_gen #(
    parameter int ADDR_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              step,
    input  logic              present,
    output logic              word_last,
    output logic [ADDR_W-1:0] addr_out
);

    logic [ADDR_W-1:0] idx_q;

    // Ascending word index, restarted at each pass.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (clear) begin
            idx_q <= '0;
        end else if (step) begin
            idx_q <= idx_q + 1'b1;
        end
    end

    // Address driven to the memory, updated only on request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_out <= '0;
        end else if (present) begin
            addr_out <= idx_q;
        end
    end

    assign word_last = (idx_q == {ADDR_W{1'b1}});

endmodule

// File: rtl/sweep_fail_log.sv
// Word comparator and first-failure record.
// Assumes: `sample` is high for exactly one cycle per read, on the cycle in
// which the memory data is valid; `clear` comes with an accepted start.
module sweep_fail_log #(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              sample,
    input  logic              blank_pass,
    input  logic [1:0]        pass_in,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] rd_data,
    input  logic [DATA_W-1:0] ref_word,
    output logic              mismatch,
    output logic              fail_seen,
    output logic [ADDR_W-1:0] fail_addr,
    output logic [DATA_W-1:0] fail_data,
    output logic [1:0]        fail_pass
);

    logic [DATA_W-1:0] want;

    // Blank passes expect all zeros; margin passes expect the image word.
    always_comb begin
        want     = blank_pass ? '0 : ref_word;
        mismatch = (rd_data != want);
    end

    // Record only the first mismatch of a run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fail_seen <= 1'b0;
            fail_addr <= '0;
            fail_data <= '0;
            fail_pass <= '0;
        end else if (clear) begin
            fail_seen <= 1'b0;
        end else if (sample && mismatch && !fail_seen) begin
            fail_seen <= 1'b1;
            fail_addr <= addr_in;
            fail_data <= rd_data;
            fail_pass <= pass_in;
        end
    end

endmodule

// File: rtl/prom_margin_sweeper.sv
// Sweeps every word of an external PROM in blank mode (one nominal pass,
// all zeros expected) or margin mode (low then high supply, compared with
// an expected image). Each read: CE high TD_CYC, address then SETUP_CYC,
// CE low ACCESS_CYC, sample on the last low cycle.
// Assumes: all cycle counts are at least 1; the image lookup is combinational.
module prom_margin_sweeper
    import prom_sweep_pkg::*;
#(
    parameter int ADDR_W     = 13,
    parameter int DATA_W     = 8,
    parameter int TD_CYC     = 250,
    parameter int SETUP_CYC  = 2,
    parameter int ACCESS_CYC = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              margin_mode,
    input  logic              stop_on_fail,
    output logic [1:0]        supply_sel,
    output logic              prom_ce_n,
    output logic              prom_oe_n,
    output logic [ADDR_W-1:0] prom_addr,
    input  logic [DATA_W-1:0] prom_data,
    output logic [ADDR_W-1:0] ref_addr,
    input  logic [DATA_W-1:0] ref_data,
    output logic              busy,
    output logic              done,
    output logic              device_ok,
    output logic              fail_seen,
    output logic [1:0]        pass_num,
    output logic [1:0]        fail_pass,
    output logic [ADDR_W-1:0] fail_addr,
    output logic [DATA_W-1:0] fail_data
);

    localparam int MAX_A   = (TD_CYC > SETUP_CYC) ? TD_CYC : SETUP_CYC;
    localparam int MAX_CYC = (MAX_A > ACCESS_CYC) ? MAX_A : ACCESS_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] TD_LOAD  = CNT_W'(TD_CYC - 1);
    localparam logic [CNT_W-1:0] SU_LOAD  = CNT_W'(SETUP_CYC - 1);
    localparam logic [CNT_W-1:0] AC_LOAD  = CNT_W'(ACCESS_CYC - 1);

    sweep_state_t state_q, state_d;
    sweep_pass_t  pass_q;
    logic         stop_q;
    logic [1:0]   supply_q;
    logic         done_q;

    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_zero;
    logic             present, step, clear_idx, go;
    logic             word_last, mismatch;
    logic             sample, abort_run, finish, next_pass;

    sweep_delay #(.CNT_W(CNT_W)) u_delay (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_zero)
    );

    sweep_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (clear_idx),
        .step      (step),
        .present   (present),
        .word_last (word_last),
        .addr_out  (prom_addr)
    );

    sweep_fail_log #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_log (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (go),
        .sample     (sample),
        .blank_pass (pass_q == PASS_BLANK),
        .pass_in    (pass_q),
        .addr_in    (prom_addr),
        .rd_data    (prom_data),
        .ref_word   (ref_data),
        .mismatch   (mismatch),
        .fail_seen  (fail_seen),
        .fail_addr  (fail_addr),
        .fail_data  (fail_data),
        .fail_pass  (fail_pass)
    );

    // End-of-read decisions: abort, finish the run, or move to the high pass.
    always_comb begin
        sample    = (state_q == ST_ACCESS) && tmr_zero;
        abort_run = sample && mismatch && stop_q;
        finish    = sample && (abort_run || (word_last && pass_q != PASS_LOW));
        next_pass = sample && !abort_run && word_last && (pass_q == PASS_LOW);
    end

    // Phase sequencing and timer loads.
    always_comb begin
        state_d   = state_q;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        present   = 1'b0;
        step      = 1'b0;
        clear_idx = 1'b0;
        go        = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (start) begin
                    go        = 1'b1;
                    clear_idx = 1'b1;
                    state_d   = ST_SETTLE;
                    tmr_load  = 1'b1;
                    tmr_val   = TD_LOAD;
                end
            end
            ST_SETTLE: begin
                if (tmr_zero) begin
                    state_d  = ST_GAP;
                    tmr_load = 1'b1;
                    tmr_val  = TD_LOAD;
                end
            end
            ST_GAP: begin
                if (tmr_zero) begin
                    state_d  = ST_SETUP;
                    tmr_load = 1'b1;
                    tmr_val  = SU_LOAD;
                    present  = 1'b1;
                end
            end
            ST_SETUP: begin
                if (tmr_zero) begin
                    state_d  = ST_ACCESS;
                    tmr_load = 1'b1;
                    tmr_val  = AC_LOAD;
                end
            end
            ST_ACCESS: begin
                if (finish) begin
                    state_d = ST_IDLE;
                end else if (next_pass) begin
                    state_d   = ST_SETTLE;
                    tmr_load  = 1'b1;
                    tmr_val   = TD_LOAD;
                    clear_idx = 1'b1;
                end else if (sample) begin
                    state_d  = ST_GAP;
                    tmr_load = 1'b1;
                    tmr_val  = TD_LOAD;
                    step     = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Run-level registers: phase, pass, stop setting, supply code, done flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            pass_q   <= PASS_BLANK;
            stop_q   <= 1'b0;
            supply_q <= SUP_NOM;
            done_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (go) begin
                pass_q   <= margin_mode ? PASS_LOW : PASS_BLANK;
                supply_q <= margin_mode ? SUP_LOW : SUP_NOM;
                stop_q   <= stop_on_fail;
                done_q   <= 1'b0;
            end else if (next_pass) begin
                pass_q   <= PASS_HIGH;
                supply_q <= SUP_HIGH;
            end else if (finish) begin
                supply_q <= SUP_NOM;
                done_q   <= 1'b1;
            end
        end
    end

    assign supply_sel = supply_q;
    assign prom_ce_n  = (state_q != ST_ACCESS);
    assign prom_oe_n  = 1'b0;
    assign ref_addr   = prom_addr;
    assign busy       = (state_q != ST_IDLE);
    assign done       = done_q;
    assign device_ok  = done_q & ~fail_seen;
    assign pass_num   = pass_q;

endmodule

// File: rtl/prom_margin_sweeper_chk.sv
// Protocol checker for prom_margin_sweeper, attached by bind.
// Counts consecutive CE-low and CE-high cycles to check read-window widths.
module prom_margin_sweeper_chk #(
    parameter int ADDR_W     = 13,
    parameter int DATA_W     = 8,
    parameter int TD_CYC     = 250,
    parameter int SETUP_CYC  = 2,
    parameter int ACCESS_CYC = 15
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        supply_sel,
    input logic              prom_ce_n,
    input logic [ADDR_W-1:0] prom_addr,
    input logic              busy,
    input logic              done,
    input logic              fail_seen,
    input logic [ADDR_W-1:0] fail_addr,
    input logic [DATA_W-1:0] fail_data
);

    int low_cnt;
    int high_cnt;

    // Length of the current CE-low / CE-high stretch (high saturates).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_cnt  <= 0;
            high_cnt <= 0;
        end else if (prom_ce_n) begin
            low_cnt <= 0;
            if (high_cnt < 1000000) high_cnt <= high_cnt + 1;
        end else begin
            high_cnt <= 0;
            low_cnt  <= low_cnt + 1;
        end
    end

    assert_access_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prom_ce_n) |-> (low_cnt == ACCESS_CYC));

    assert_high_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(prom_ce_n) |-> (high_cnt >= TD_CYC + SETUP_CYC));

    assert_addr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!prom_ce_n && $past(!prom_ce_n)) |-> $stable(prom_addr));

    assert_supply_steady_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !prom_ce_n |-> $stable(supply_sel));

    assert_idle_safe_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (prom_ce_n && supply_sel == 2'b00));

    assert_done_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && busy));

    assert_first_fail_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_seen && $past(fail_seen)) |-> ($stable(fail_addr) && $stable(fail_data)));

endmodule

bind prom_margin_sweeper prom_margin_sweeper_chk #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .TD_CYC     (TD_CYC),
    .SETUP_CYC  (SETUP_CYC),
    .ACCESS_CYC (ACCESS_CYC)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .supply_sel (supply_sel),
    .prom_ce_n  (prom_ce_n),
    .prom_addr  (prom_addr),
    .busy       (busy),
    .done       (done),
    .fail_seen  (fail_seen),
    .fail_addr  (fail_addr),
    .fail_data  (fail_data)
);

// File: tb/test_prom_margin_sweeper.sv
// Bench: a behavioural memory model (data valid only late in the CE-low
// window, optional supply-dependent weak bits) and a per-cycle expected
// schedule held in queues, compared on every falling clock edge.
module test_prom_margin_sweeper;

    localparam int AW = 5;
    localparam int DW = 8;
    localparam int TD = 3;
    localparam int SU = 2;
    localparam int AC = 4;
    localparam int WORDS = 1 << AW;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          margin_mode = 1'b0;
    logic          stop_on_fail = 1'b0;
    logic [1:0]    supply_sel;
    logic          prom_ce_n, prom_oe_n;
    logic [AW-1:0] prom_addr, ref_addr, fail_addr;
    logic [DW-1:0] prom_data, ref_data, fail_data;
    logic          busy, done, device_ok, fail_seen;
    logic [1:0]    pass_num, fail_pass;

    logic [DW-1:0] mem   [WORDS];
    logic [DW-1:0] image [WORDS];
    int weak_low  = -1;
    int weak_high = -1;
    int low_cyc   = 0;

    int checks = 0;
    int bad    = 0;

    int q_ce[$], q_addr[$], q_sup[$], q_pass[$];
    int cur_addr = 0;
    int cur_pass = 0;
    bit exp_fail;
    int exp_fa, exp_fd, exp_fp;

    prom_margin_sweeper #(
        .ADDR_W(AW), .DATA_W(DW), .TD_CYC(TD), .SETUP_CYC(SU), .ACCESS_CYC(AC)
    ) i_prom_margin_sweeper (
        .clk(clk), .rst_n(rst_n), .start(start), .margin_mode(margin_mode),
        .stop_on_fail(stop_on_fail), .supply_sel(supply_sel),
        .prom_ce_n(prom_ce_n), .prom_oe_n(prom_oe_n), .prom_addr(prom_addr),
        .prom_data(prom_data), .ref_addr(ref_addr), .ref_data(ref_data),
        .busy(busy), .done(done), .device_ok(device_ok), .fail_seen(fail_seen),
        .pass_num(pass_num), .fail_pass(fail_pass), .fail_addr(fail_addr),
        .fail_data(fail_data)
    );

    function automatic logic [DW-1:0] prom_read(int a, int sup);
        logic [DW-1:0] v;
        v = mem[a];
        if (sup == 1 && a == weak_low)  v = v ^ 8'h10;
        if (sup == 2 && a == weak_high) v = v ^ 8'h01;
        return v;
    endfunction

    // Cycles chip enable has been low; data is valid only from AC-1 on.
    always @(posedge clk) begin
        if (prom_ce_n) low_cyc <= 0;
        else           low_cyc <= low_cyc + 1;
    end

    assign prom_data = (!prom_ce_n && low_cyc >= AC - 1)
                       ? prom_read(int'(prom_addr), int'(supply_sel)) : 8'hC3;
    assign ref_data  = image[ref_addr];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic push(input int ce, input int a, input int s, input int p);
        q_ce.push_back(ce);
        q_addr.push_back(a);
        q_sup.push_back(s);
        q_pass.push_back(p);
    endtask

    // Expected cycle schedule; the supply code equals the pass number.
    task automatic build(input bit mode, input bit stop);
        int plist[$];
        bit aborted;
        aborted  = 1'b0;
        exp_fail = 1'b0;
        if (mode) plist = '{1, 2};
        else      plist = '{0};
        foreach (plist[i]) begin
            int p;
            p = plist[i];
            cur_pass = p;
            repeat (TD) push(1, cur_addr, p, p);          // R4 settle after supply change
            for (int w = 0; w < WORDS; w++) begin
                logic [DW-1:0] d, e;
                repeat (TD) push(1, cur_addr, p, p);      // R5 CE high, old address
                cur_addr = w;
                repeat (SU) push(1, w, p, p);             // R5 setup with new address
                repeat (AC) push(0, w, p, p);             // R5 access window
                d = prom_read(w, p);
                e = (p == 0) ? '0 : image[w];
                if (d != e) begin
                    if (!exp_fail) begin
                        exp_fail = 1'b1;
                        exp_fa = w;
                        exp_fd = int'(d);
                        exp_fp = p;
                    end
                    if (stop) begin
                        aborted = 1'b1;
                        break;
                    end
                end
            end
            if (aborted) break;
        end
    endtask

    task automatic run(input bit mode, input bit stop, input int inject_at);
        int idx;
        build(mode, stop);
        @(negedge clk);
        margin_mode  = mode;
        stop_on_fail = stop;
        start        = 1'b1;
        idx = 0;
        while (q_ce.size() > 0) begin
            int e_ce, e_a, e_s, e_p;
            @(negedge clk);
            e_ce = q_ce.pop_front();
            e_a  = q_addr.pop_front();
            e_s  = q_sup.pop_front();
            e_p  = q_pass.pop_front();
            chk(int'(prom_ce_n) == e_ce, "R5 chip enable", int'(prom_ce_n), e_ce);
            chk(int'(prom_addr) == e_a,  "R6 address", int'(prom_addr), e_a);
            chk(int'(ref_addr) == e_a,   "R3 lookup address", int'(ref_addr), e_a);
            chk(int'(supply_sel) == e_s, "R3 supply code", int'(supply_sel), e_s);
            chk(int'(pass_num) == e_p,   "R2 pass number", int'(pass_num), e_p);
            chk(busy == 1'b1,            "R10 busy during run", int'(busy), 1);
            chk(prom_oe_n == 1'b0,       "R11 output enable", int'(prom_oe_n), 0);
            // R10: a start pulse with the other mode while busy
            start       = (idx == inject_at);
            margin_mode = (idx == inject_at) ? !mode : mode;
            stop_on_fail = (idx == inject_at) ? !stop : stop;
            idx++;
        end
        start = 1'b0;
        @(negedge clk);
        chk(busy == 1'b0,             "R9 busy falls", int'(busy), 0);
        chk(done == 1'b1,             "R9 done rises", int'(done), 1);
        chk(prom_ce_n == 1'b1,        "R9 chip enable high", int'(prom_ce_n), 1);
        chk(supply_sel == 2'b00,      "R9 supply nominal", int'(supply_sel), 0);
        chk(int'(pass_num) == cur_pass, "R2 final pass", int'(pass_num), cur_pass);
        chk(device_ok == !exp_fail,   "R7 device ok", int'(device_ok), int'(!exp_fail));
        chk(fail_seen == exp_fail,    "R7 fail seen", int'(fail_seen), int'(exp_fail));
        if (exp_fail) begin
            chk(int'(fail_addr) == exp_fa, "R7 fail address", int'(fail_addr), exp_fa);
            chk(int'(fail_data) == exp_fd, "R7 fail data", int'(fail_data), exp_fd);
            chk(int'(fail_pass) == exp_fp, "R8 fail pass", int'(fail_pass), exp_fp);
        end
        repeat (3) @(negedge clk);
        chk(done == 1'b1 && busy == 1'b0, "R9 done held", int'(done), 1);
        chk(prom_ce_n == 1'b1,            "R8 no further reads", int'(prom_ce_n), 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog R9 act=%0d exp=%0d", 0, 1);
        $display("  test done: total=%0d bad=%0d", checks + 1, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < WORDS; i++) begin
            mem[i]   = '0;
            image[i] = DW'(i * 37 + 5);
        end
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(prom_ce_n == 1'b1,   "R1 chip enable", int'(prom_ce_n), 1);
        chk(prom_oe_n == 1'b0,   "R1 output enable", int'(prom_oe_n), 0);
        chk(supply_sel == 2'b00, "R1 supply", int'(supply_sel), 0);
        chk(prom_addr == '0,     "R1 address", int'(prom_addr), 0);
        chk(pass_num == 2'd0,    "R1 pass", int'(pass_num), 0);
        chk(!busy && !done && !fail_seen, "R1 status", int'({busy, done, fail_seen}), 0);

        // R2 blank device, image ignored
        run(1'b0, 1'b0, -1);

        // R2 R7 one programmed word, sweep continues past it
        mem[7] = 8'h40;
        mem[12] = 8'h02;
        run(1'b0, 1'b0, -1);

        // R8 stop at first of two programmed words
        mem[7] = '0; mem[12] = '0;
        mem[3] = 8'h01; mem[20] = 8'h80;
        run(1'b0, 1'b1, -1);

        // R3 R10 programmed device matching image, stray start mid-run
        for (int i = 0; i < WORDS; i++) mem[i] = image[i];
        run(1'b1, 1'b0, 50);

        // R3 R7 weak bit at low supply only, both passes still run
        weak_low = 9;
        run(1'b1, 1'b0, -1);

        // R8 last word fails at high supply with stop set
        weak_low  = -1;
        weak_high = WORDS - 1;
        run(1'b1, 1'b1, -1);

        // R8 last word fails at low supply with stop set: high pass skipped
        weak_high = -1;
        weak_low  = WORDS - 1;
        run(1'b1, 1'b1, -1);
        weak_low = -1;

        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule